// File: doc/BRIEF.md
# Amplitude-Tracking PWM Gain Control Generator

This block closes a slow automatic gain loop around an external analog amplifier. It receives signed in-phase and quadrature baseband samples with a valid strobe. For each accepted sample it forms the magnitude sum |I| + |Q| and adds it to a window total. Once a fixed number of accepted samples has arrived, the window average is compared with a programmable target. The difference, shifted down by a programmable amount, is added to a saturating gain word.

The upper bits of the gain word set the duty cycle of a single-bit pulse-width-modulated output. An external RC network smooths that output into the amplifier's control voltage. The output is built from slots of a fixed minimum length, so the line can never toggle faster than that slot allows. The pad is either driven push-pull or run open-drain, where it only pulls low or lets go. The target, shift and pad mode come in as plain configuration inputs from a register block outside this one.

Top module: `agc_pwm_gen`

## Requirements
- R1: After reset the gain word is mid-scale (512 for a 10-bit gain), and in open-drain mode the pad is released (`pad_oe_o` = 0, `pad_o` = 0).
- R2: The gain word changes only at the clock edge that accepts the 2048th valid sample of a window. Cycles with `smp_vld_i` = 0 are not counted and their sample values have no effect.
- R3: Samples are two's complement. The sample magnitude is |I| + |Q|, and the window average is the window total divided by 2048 with the fraction dropped. At each window end the gain adds (target − average) arithmetically shifted right by `shift_i`, so a negative result rounds toward minus infinity.
- R4: The gain word saturates at 0 and at 1023 and never wraps.
- R5: The duty value d is `gain_o[9:4]`. A PWM period is 64 slots of 4 clocks each, and the level is high during the first d slots. With d = 0 the level is constantly low, and with d = 63 it is constantly high.
- R6: Every high or low interval of the PWM level lasts at least 4 clocks.
- R7: With `od_mode_i` = 1, `pad_o` is always 0 and `pad_oe_o` is the inverse of the PWM level. With `od_mode_i` = 0, `pad_oe_o` is 1 and `pad_o` carries the level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| smp_vld_i | input | 1 | Sample strobe; the sample is accepted when high |
| smp_i_i | input | 6 | Signed in-phase sample |
| smp_q_i | input | 6 | Signed quadrature sample |
| target_i | input | 7 | Desired window average of \|I\|+\|Q\| |
| shift_i | input | 3 | Loop gain as a right shift of the error |
| od_mode_i | input | 1 | 1 selects open-drain pad behaviour, 0 selects push-pull |
| gain_o | output | 10 | Current gain word |
| pad_o | output | 1 | Pad data value |
| pad_oe_o | output | 1 | Pad output enable |

## Verification
The bench drives windows that are padded with invalid cycles carrying full-scale negative samples. A design that counted those cycles or summed their samples would update early or land on a wrong gain. Signed extremes (−32), a negative error that shifts to −1 instead of 0, and runs into both saturation rails are targeted; a wrapping accumulator would jump from 1023 to a small value or from 0 to a large one. Duty values 0, 28, 32 and 63 are measured over whole periods in both pad modes, and a continuous run-length monitor flags any pulse shorter than four clocks.

// File: rtl/agc_pkg.sv
package agc_pkg;

  // Magnitude of a signed integer.
  function automatic int f_abs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  // Next gain value: error against target, arithmetic shift, clamp to [0, gmax].
  function automatic int f_next_gain(input int gain, input int avg, input int tgt,
                                     input int sh, input int gmax);
    int err;
    int step;
    int nxt;
    err  = tgt - avg;
    step = err >>> sh;
    nxt  = gain + step;
    if (nxt < 0)    nxt = 0;
    if (nxt > gmax) nxt = gmax;
    return nxt;
  endfunction

endpackage

// File: rtl/agc_amp_est.sv
module agc_amp_est #(
  parameter int SAMP_W   = 6,
  parameter int WIN_LOG2 = 11,
  parameter int AVG_W    = SAMP_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [SAMP_W-1:0] smp_i_i,
  input  logic [SAMP_W-1:0] smp_q_i,
  output logic              win_done_o,
  output logic [AVG_W-1:0]  avg_o
);
  localparam int SUM_W = AVG_W + WIN_LOG2;

  logic [WIN_LOG2-1:0] cnt_q;
  logic [SUM_W-1:0]    sum_q;
  logic [AVG_W-1:0]    mag;
  logic [SUM_W-1:0]    total;
  logic                last_smp;

  always_comb begin
    mag = AVG_W'(agc_pkg::f_abs(int'($signed(smp_i_i))) +
                 agc_pkg::f_abs(int'($signed(smp_q_i))));
  end

  assign total      = sum_q + SUM_W'(mag);
  assign last_smp   = &cnt_q;
  assign win_done_o = vld_i & last_smp;
  assign avg_o      = total[SUM_W-1 -: AVG_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sum_q <= '0;
    end else if (vld_i) begin
      cnt_q <= cnt_q + WIN_LOG2'(1);
      sum_q <= last_smp ? '0 : total;
    end
  end
endmodule

// File: rtl/agc_gain_loop.sv
module agc_gain_loop #(
  parameter int GAIN_W  = 10,
  parameter int AVG_W   = 7,
  parameter int SHIFT_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               win_done_i,
  input  logic [AVG_W-1:0]   avg_i,
  input  logic [AVG_W-1:0]   target_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic [GAIN_W-1:0]  gain_o
);
  localparam int GMAX = (2 ** GAIN_W) - 1;
  localparam logic [GAIN_W-1:0] GMID = GAIN_W'(2 ** (GAIN_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gain_o <= GMID;
    end else if (win_done_i) begin
      gain_o <= GAIN_W'(agc_pkg::f_next_gain(int'(gain_o), int'(avg_i), int'(target_i),
                                             int'(shift_i), GMAX));
    end
  end
endmodule

// File: rtl/agc_pwm_enc.sv
module agc_pwm_enc #(
  parameter int DUTY_W    = 6,
  parameter int MIN_PULSE = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic              od_mode_i,
  output logic              level_o,
  output logic              pad_o,
  output logic              pad_oe_o
);
  localparam int SUB_W = (MIN_PULSE > 1) ? $clog2(MIN_PULSE) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(MIN_PULSE - 1);

  logic [SUB_W-1:0]  sub_q;
  logic [DUTY_W-1:0] slot_q;
  logic [DUTY_W-1:0] nxt_slot;
  logic              slot_end;
  logic              nxt_level;

  assign slot_end  = (sub_q == SUB_LAST);
  assign nxt_slot  = slot_q + DUTY_W'(1);
  assign nxt_level = (&duty_i) | (nxt_slot < duty_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_q   <= '0;
      slot_q  <= '0;
      level_o <= 1'b1;
    end else if (slot_end) begin
      sub_q   <= '0;
      slot_q  <= nxt_slot;
      level_o <= nxt_level;
    end else begin
      sub_q   <= sub_q + SUB_W'(1);
    end
  end

  generate
    if (MIN_PULSE > 0) begin : g_pad
      always_comb begin
        if (od_mode_i) begin
          pad_o    = 1'b0;
          pad_oe_o = ~level_o;
        end else begin
          pad_o    = level_o;
          pad_oe_o = 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/agc_pwm_gen.sv
module agc_pwm_gen #(
  parameter int SAMP_W    = 6,
  parameter int WIN_LOG2  = 11,
  parameter int GAIN_W    = 10,
  parameter int DUTY_W    = 6,
  parameter int SHIFT_W   = 3,
  parameter int MIN_PULSE = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 smp_vld_i,
  input  logic [SAMP_W-1:0]    smp_i_i,
  input  logic [SAMP_W-1:0]    smp_q_i,
  input  logic [SAMP_W:0]      target_i,
  input  logic [SHIFT_W-1:0]   shift_i,
  input  logic                 od_mode_i,
  output logic [GAIN_W-1:0]    gain_o,
  output logic                 pad_o,
  output logic                 pad_oe_o
);
  localparam int AVG_W = SAMP_W + 1;

  logic              win_done;
  logic [AVG_W-1:0]  win_avg;
  logic [DUTY_W-1:0] duty;
  logic              pwm_lvl;

  agc_amp_est #(.SAMP_W(SAMP_W), .WIN_LOG2(WIN_LOG2), .AVG_W(AVG_W)) u_est (
    .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(smp_vld_i),
    .smp_i_i(smp_i_i), .smp_q_i(smp_q_i),
    .win_done_o(win_done), .avg_o(win_avg)
  );

  agc_gain_loop #(.GAIN_W(GAIN_W), .AVG_W(AVG_W), .SHIFT_W(SHIFT_W)) u_loop (
    .clk_i(clk_i), .rst_ni(rst_ni), .win_done_i(win_done),
    .avg_i(win_avg), .target_i(target_i), .shift_i(shift_i), .gain_o(gain_o)
  );

  assign duty = gain_o[GAIN_W-1 -: DUTY_W];

  agc_pwm_enc #(.DUTY_W(DUTY_W), .MIN_PULSE(MIN_PULSE)) u_pwm (
    .clk_i(clk_i), .rst_ni(rst_ni), .duty_i(duty), .od_mode_i(od_mode_i),
    .level_o(pwm_lvl), .pad_o(pad_o), .pad_oe_o(pad_oe_o)
  );
endmodule

// File: rtl/agc_pwm_gen_chk.sv
module agc_pwm_gen_chk #(
  parameter int GAIN_W    = 10,
  parameter int DUTY_W    = 6,
  parameter int AVG_W     = 7,
  parameter int MIN_PULSE = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              win_done,
  input logic [AVG_W-1:0]  avg,
  input logic [AVG_W-1:0]  target,
  input logic [GAIN_W-1:0] gain,
  input logic [DUTY_W-1:0] duty,
  input logic              level,
  input logic              od_mode,
  input logic              pad_o,
  input logic              pad_oe
);
  logic [7:0] run_q;
  logic       prev_lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q      <= 8'hFF;
      prev_lvl_q <= 1'b1;
    end else begin
      prev_lvl_q <= level;
      if (level != prev_lvl_q) run_q <= 8'd1;
      else if (run_q != 8'hFF) run_q <= run_q + 8'd1;
    end
  end

  assert_gain_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_done |=> $stable(gain));

  assert_step_up_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_done && avg < target) |=> (gain >= $past(gain)));

  assert_step_down_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_done && avg > target) |=> (gain <= $past(gain)));

  assert_rise_needs_duty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(level) |-> ($past(duty) != '0));

  assert_fall_needs_gap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(level) |-> ($past(duty) != '1));

  assert_min_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level != prev_lvl_q) |-> (run_q >= 8'(MIN_PULSE)));

  assert_od_pad_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    od_mode |-> (!pad_o && (pad_oe == !level)));

  assert_pp_pad_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !od_mode |-> (pad_oe && (pad_o == level)));
endmodule

bind agc_pwm_gen agc_pwm_gen_chk #(
  .GAIN_W(GAIN_W), .DUTY_W(DUTY_W), .AVG_W(AVG_W), .MIN_PULSE(MIN_PULSE)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .win_done(win_done), .avg(win_avg),
  .target(target_i), .gain(gain_o), .duty(duty), .level(pwm_lvl),
  .od_mode(od_mode_i), .pad_o(pad_o), .pad_oe(pad_oe_o)
);

// File: tb/agc_pwm_gen_bench.sv
`timescale 1ns/1ps
module agc_pwm_gen_bench;
  localparam real CLK_NS = 5.0;
  localparam int  WIN    = 2048;

  typedef struct packed {
    int si; int sq; int tgt; int sh; int exp_gain;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{ 10, -10,  40, 0,  532},
    '{-32, -32,  40, 2,  526},
    '{  5,   3, 100, 0,  618},
    '{  0,   0, 127, 0,  745},
    '{  0,   0, 127, 0,  872},
    '{  0,   0, 127, 0,  999},
    '{  0,   0, 127, 0, 1023},
    '{ 20, -20,  39, 3, 1022}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vld = 1'b0;
  logic [5:0] si = '0, sq = '0;
  logic [6:0] tgt = '0;
  logic [2:0] sh = '0;
  logic       od = 1'b1;
  logic [9:0] gain;
  logic       pad, pad_oe;

  int n_chk = 0, n_fail = 0, short_pulses = 0;

  always #(CLK_NS/2) clk = ~clk;

  agc_pwm_gen u_agc_pwm_gen (
    .clk_i(clk), .rst_ni(rst_n), .smp_vld_i(vld), .smp_i_i(si), .smp_q_i(sq),
    .target_i(tgt), .shift_i(sh), .od_mode_i(od),
    .gain_o(gain), .pad_o(pad), .pad_oe_o(pad_oe)
  );

  // Observed line level: a released open-drain pad is pulled high.
  logic line;
  assign line = pad_oe ? pad : 1'b1;

  // R6 run-length monitor, sampled at the falling edge.
  int  run = 1000;
  logic last_line = 1'b1;
  always @(negedge clk) begin
    if (!rst_n) begin
      run = 1000; last_line = line;
    end else if (line != last_line) begin
      if (run < 4) short_pulses++;
      run = 1; last_line = line;
    end else begin
      run++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One window of constant samples, with idle cycles of garbage interleaved.
  task automatic run_window(input int i, input int q, input int t, input int s, input int prev);
    tgt = 7'(t); sh = 3'(s);
    for (int k = 0; k < WIN; k++) begin
      if (k % 16 == 15) begin
        @(negedge clk); vld = 1'b0; si = 6'h20; sq = 6'h20;
      end
      @(negedge clk);
      if (k == WIN - 1) chk("R2 hold before last sample", int'(gain), prev);
      vld = 1'b1; si = 6'(i); sq = 6'(q);
    end
    @(negedge clk); vld = 1'b0; si = 6'h20; sq = 6'h20;
  endtask

  task automatic measure(output int hi, output int oe_n, output int pad_n);
    hi = 0; oe_n = 0; pad_n = 0;
    for (int c = 0; c < 256; c++) begin
      @(negedge clk);
      if (line) hi++;
      if (pad_oe) oe_n++;
      if (pad) pad_n++;
    end
  endtask

  initial begin
    #(CLK_NS * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int hi, oe_n, pad_n, expg;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset gain", int'(gain), 512);
    chk("R1 reset pad_oe", int'(pad_oe), 0);
    chk("R1 reset pad_o", int'(pad), 0);

    // Mid duty in both pad modes (R5, R7).
    measure(hi, oe_n, pad_n);
    chk("R7 od pad_oe cycles at duty 32", oe_n, 128);
    chk("R7 od pad_o never high", pad_n, 0);
    od = 1'b0;
    measure(hi, oe_n, pad_n);
    chk("R5 high cycles at duty 32", hi, 128);
    chk("R7 pp pad_oe always on", oe_n, 256);

    // Table walk (R2, R3, R4).
    expg = 512;
    foreach (VECS[n]) begin
      run_window(VECS[n].si, VECS[n].sq, VECS[n].tgt, VECS[n].sh, expg);
      chk($sformatf("R3 R4 gain after window %0d", n), int'(gain), VECS[n].exp_gain);
      expg = VECS[n].exp_gain;
    end

    // Duty 63: constant high.
    measure(hi, oe_n, pad_n);
    chk("R5 duty 63 constant high", hi, 256);
    od = 1'b1;
    measure(hi, oe_n, pad_n);
    chk("R7 od released at duty 63", oe_n, 0);

    // Back to mid-scale, then drive down to the low rail.
    rst_n = 1'b0; repeat (2) @(negedge clk); rst_n = 1'b1; @(negedge clk);
    chk("R1 gain after second reset", int'(gain), 512);
    od = 1'b0;
    expg = 512;
    for (int w = 0; w < 9; w++) begin
      run_window(-32, -32, 0, 0, expg);
      expg = (expg > 64) ? expg - 64 : 0;
      chk($sformatf("R4 gain descending window %0d", w), int'(gain), expg);
      if (w == 0) begin
        measure(hi, oe_n, pad_n);
        chk("R5 high cycles at duty 28", hi, 112);
      end
    end
    measure(hi, oe_n, pad_n);
    chk("R5 duty 0 constant low", hi, 0);

    chk("R6 pulses shorter than four clocks", short_pulses, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule